// File: doc/BRIEF.md
# NAND Flash Bus Bridge

This block connects a simple memory-mapped bus to an 8-bit asynchronous NAND flash device. The bus addresses two spaces. One is a register bank: per-chip timing and control words, a status word, a mode word and a small ECC register group. The other is a data window that turns each bus access into one NAND strobe cycle. Inside the window, the low address bits of the access choose what kind of cycle goes out. One bit raises the command-latch strobe, another raises the address-latch strobe, and with neither bit set the cycle carries plain data. Software can therefore send a command byte, several address bytes and then data, using nothing but window accesses at different offsets.

Every window access runs a setup, strobe and hold sequence. The three lengths come from the timing word of the chip currently chosen in the mode register. The bus is held off with a wait signal until the sequence finishes. A sticky bit in each chip's first control word keeps that chip enabled between accesses, so a multi-byte command stays framed. The flash ready/busy line is synchronized and shown in the status word. A write to the ECC start-address register sends a one-cycle arm pulse to an external ECC engine.

Top module: `nand_bus_bridge`

## Requirements
- R1: After reset, every chip enable is high, both strobes are high, the command and address latch outputs are low, the bus wait is low while no window access is requested, and every register in the bank reads 0.
- R2: During a window access, address bit 2 set drives the command-latch output high. Bit 3 set with bit 2 clear drives the address-latch output high. With both clear, neither latch output is raised. If both bits are set, the command latch wins.
- R3: A window write gives exactly one write-enable low pulse and no read-enable pulse. While write enable is low, the data output carries bus_wdata[7:0] and the output enable is high.
- R4: A window read gives exactly one read-enable low pulse, with the output enable low. When the access completes, bus_rdata[7:0] holds the NAND data input captured on the last strobe cycle, and bus_rdata[31:8] is 0.
- R5: Word 0 of each chip holds the timing fields: setup in bits [3:0], strobe width in bits [7:4] and hold in bits [15:12], each giving N. A window access drives its strobe low for width+1 cycles and holds bus_wait high for setup+width+hold+4 cycles, counting the request cycle.
- R6: Bits [1:0] of the mode register (offset 0x38) choose the chip for window accesses. While the strobe is low, only that chip's enable is low, unless other chips are forced as R7 describes.
- R7: Bit 9 of a chip's word 0 holds that chip's enable low while it is set, including when the bridge is idle. Clearing the bit releases the enable.
- R8: Chip c word w sits at byte offset 4*(3c+w), covering 0x00 to 0x2C. The mode register, ECC code (0x40), ECC count (0x44) and ECC start address (0x48) read back what was written. Register accesses never raise bus_wait.
- R9: Status (0x30) bit 0 shows the ready/busy input after two clock edges of synchronization. All other status bits read 0, and writes to the status register are ignored.
- R10: A write to offset 0x48 raises ecc_arm for exactly the one cycle after the write edge. Writes to other offsets leave it low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_req | input | 1 | Bus access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_win | input | 1 | 1 = data window, 0 = register bank |
| bus_addr | input | 8 | Byte address within the selected space |
| bus_wdata | input | 32 | Write data (window uses bits [7:0]) |
| bus_rdata | output | 32 | Read data |
| bus_wait | output | 1 | Stall while a window access is in progress |
| nand_ce_n | output | 4 | Per-chip enables, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_out | output | 8 | Data to the flash |
| nand_dq_oe | output | 1 | Data output enable |
| nand_dq_in | input | 8 | Data from the flash |
| nand_rb | input | 1 | Ready/busy, 1 = ready |
| ecc_arm | output | 1 | One-cycle arm pulse to the ECC engine |

## Verification
The assertions check rules that must hold on every cycle. The two strobes are never low together, and the two latch outputs are never high together. Some chip enable is always low while a strobe is low. The data bus is driven during a write strobe. Register accesses never stall, and a completed window access leaves both strobes high. Every arm pulse follows a write to the start-address offset. The bench scenarios cover what depends on values. These are the decoding of the window address bits, the exact pulse and stall lengths taken from the timing fields, the chip chosen by the mode word, the captured read byte, the forced chip enable, register readback at the fixed offsets, and the two-edge delay of the ready/busy bit.

// File: rtl/nand_bridge_pkg.sv
package nand_bridge_pkg;

  typedef enum logic [2:0] {
    SEQ_IDLE,
    SEQ_SETUP,
    SEQ_STROBE,
    SEQ_HOLD,
    SEQ_DONE
  } seq_state_t;

  typedef enum logic [1:0] {
    CYC_DATA,
    CYC_CMD,
    CYC_ADDR
  } cyc_kind_t;

  localparam int REG_W      = 32;
  localparam int TCNT_W     = 4;
  localparam int IDX_W      = 6;
  localparam int CFG_PER_CS = 3;

  // word indices (byte offset / 4) of the fixed registers
  localparam logic [IDX_W-1:0] IDX_STATUS = 6'd12;
  localparam logic [IDX_W-1:0] IDX_MODE   = 6'd14;
  localparam logic [IDX_W-1:0] IDX_ECODE  = 6'd16;
  localparam logic [IDX_W-1:0] IDX_ECNT   = 6'd17;
  localparam logic [IDX_W-1:0] IDX_EADDR  = 6'd18;

  // command latch takes priority over address latch
  function automatic cyc_kind_t decode_kind(input logic bit2, input logic bit3);
    if (bit2)      return CYC_CMD;
    else if (bit3) return CYC_ADDR;
    else           return CYC_DATA;
  endfunction

  function automatic logic [TCNT_W-1:0] cfg_setup(input logic [REG_W-1:0] w);
    return w[3:0];
  endfunction

  function automatic logic [TCNT_W-1:0] cfg_width(input logic [REG_W-1:0] w);
    return w[7:4];
  endfunction

  function automatic logic [TCNT_W-1:0] cfg_hold(input logic [REG_W-1:0] w);
    return w[15:12];
  endfunction

  function automatic logic cfg_force(input logic [REG_W-1:0] w);
    return w[9];
  endfunction

endpackage

// File: rtl/nand_rb_sync.sv
module nand_rb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rb_async,
  output logic rb_synced
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[s] <= 1'b0;
        else if (s == 0) chain_q[s] <= rb_async;
        else chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign rb_synced = chain_q[STAGES-1];
endmodule

// File: rtl/nand_reg_bank.sv
module nand_reg_bank
  import nand_bridge_pkg::*;
#(
  parameter int NUM_CS = 4,
  localparam int NCFG  = NUM_CS * CFG_PER_CS,
  localparam int SEL_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [IDX_W-1:0]        idx,
  input  logic [REG_W-1:0]        wdata,
  input  logic                    rb_synced,
  output logic [REG_W-1:0]        rdata,
  output logic [NUM_CS*REG_W-1:0] cfg0_flat,
  output logic [SEL_W-1:0]        chip_sel,
  output logic                    ecc_arm
);
  logic [REG_W-1:0] cfg_q [NCFG];
  logic [REG_W-1:0] mode_q, ecode_q, ecnt_q, eaddr_q;
  logic             arm_q;

  generate
    for (genvar g = 0; g < NCFG; g++) begin : g_cfg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q[g] <= '0;
        else if (wr_en && idx == IDX_W'(g)) cfg_q[g] <= wdata;
      end
    end
    for (genvar c = 0; c < NUM_CS; c++) begin : g_cfg0
      assign cfg0_flat[c*REG_W +: REG_W] = cfg_q[c*CFG_PER_CS];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= '0;
      ecode_q <= '0;
      ecnt_q  <= '0;
      eaddr_q <= '0;
      arm_q   <= 1'b0;
    end else begin
      arm_q <= wr_en && (idx == IDX_EADDR);
      if (wr_en) begin
        case (idx)
          IDX_MODE:  mode_q  <= wdata;
          IDX_ECODE: ecode_q <= wdata;
          IDX_ECNT:  ecnt_q  <= wdata;
          IDX_EADDR: eaddr_q <= wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rdata = '0;
    for (int k = 0; k < NCFG; k++) begin
      if (idx == IDX_W'(k)) rdata = cfg_q[k];
    end
    case (idx)
      IDX_STATUS: rdata = {{(REG_W-1){1'b0}}, rb_synced};
      IDX_MODE:   rdata = mode_q;
      IDX_ECODE:  rdata = ecode_q;
      IDX_ECNT:   rdata = ecnt_q;
      IDX_EADDR:  rdata = eaddr_q;
      default: ;
    endcase
  end

  assign chip_sel = mode_q[SEL_W-1:0];
  assign ecc_arm  = arm_q;
endmodule

// File: rtl/nand_strobe_seq.sv
module nand_strobe_seq
  import nand_bridge_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              start_wr,
  input  cyc_kind_t         start_kind,
  input  logic [7:0]        start_data,
  input  logic [TCNT_W-1:0] t_setup,
  input  logic [TCNT_W-1:0] t_width,
  input  logic [TCNT_W-1:0] t_hold,
  input  logic [7:0]        dq_in,
  output logic              idle,
  output logic              active,
  output logic              done,
  output logic              cle,
  output logic              ale,
  output logic              we_n,
  output logic              re_n,
  output logic [7:0]        dq_out,
  output logic              dq_oe,
  output logic [7:0]        rd_byte
);
  seq_state_t        state_q;
  logic [TCNT_W-1:0] cnt_q, width_q, hold_q;
  logic              wr_q;
  cyc_kind_t         kind_q;
  logic [7:0]        data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      cnt_q   <= '0;
      width_q <= '0;
      hold_q  <= '0;
      wr_q    <= 1'b0;
      kind_q  <= CYC_DATA;
      data_q  <= '0;
      rd_byte <= '0;
    end else begin
      case (state_q)
        SEQ_IDLE: if (start) begin
          state_q <= SEQ_SETUP;
          cnt_q   <= t_setup;
          width_q <= t_width;
          hold_q  <= t_hold;
          wr_q    <= start_wr;
          kind_q  <= start_kind;
          data_q  <= start_data;
        end
        SEQ_SETUP: begin
          if (cnt_q == '0) begin
            state_q <= SEQ_STROBE;
            cnt_q   <= width_q;
          end else cnt_q <= cnt_q - 1'b1;
        end
        SEQ_STROBE: begin
          if (cnt_q == '0) begin
            state_q <= SEQ_HOLD;
            cnt_q   <= hold_q;
            if (!wr_q) rd_byte <= dq_in;
          end else cnt_q <= cnt_q - 1'b1;
        end
        SEQ_HOLD: begin
          if (cnt_q == '0) state_q <= SEQ_DONE;
          else cnt_q <= cnt_q - 1'b1;
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  assign idle   = (state_q == SEQ_IDLE);
  assign done   = (state_q == SEQ_DONE);
  assign active = (state_q == SEQ_SETUP) || (state_q == SEQ_STROBE) || (state_q == SEQ_HOLD);
  assign cle    = active && (kind_q == CYC_CMD);
  assign ale    = active && (kind_q == CYC_ADDR);
  assign we_n   = !((state_q == SEQ_STROBE) && wr_q);
  assign re_n   = !((state_q == SEQ_STROBE) && !wr_q);
  assign dq_oe  = active && wr_q;
  assign dq_out = dq_oe ? data_q : 8'h00;
endmodule

// File: rtl/nand_bus_bridge.sv
module nand_bus_bridge
  import nand_bridge_pkg::*;
#(
  parameter int NUM_CS   = 4,
  parameter int RB_STAGES = 2,
  localparam int SEL_W   = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic              bus_win,
  input  logic [7:0]        bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  output logic              bus_wait,
  output logic [NUM_CS-1:0] nand_ce_n,
  output logic              nand_cle,
  output logic              nand_ale,
  output logic              nand_we_n,
  output logic              nand_re_n,
  output logic [7:0]        nand_dq_out,
  output logic              nand_dq_oe,
  input  logic [7:0]        nand_dq_in,
  input  logic              nand_rb,
  output logic              ecc_arm
);
  // named internal events
  logic                    rb_synced;
  logic                    reg_wr;
  logic                    win_start;
  logic                    seq_idle, seq_active, seq_done;
  logic [REG_W-1:0]        reg_rdata;
  logic [NUM_CS*REG_W-1:0] cfg0_flat;
  logic [SEL_W-1:0]        chip_sel, sel_q;
  logic [REG_W-1:0]        sel_cfg;
  logic [7:0]              rd_byte;

  assign reg_wr    = bus_req && bus_we && !bus_win;
  assign win_start = bus_req && bus_win && seq_idle;
  assign sel_cfg   = cfg0_flat[chip_sel*REG_W +: REG_W];

  nand_rb_sync #(.STAGES(RB_STAGES)) rb_sync_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .rb_async  (nand_rb),
    .rb_synced (rb_synced)
  );

  nand_reg_bank #(.NUM_CS(NUM_CS)) regs_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (reg_wr),
    .idx       (bus_addr[7:2]),
    .wdata     (bus_wdata),
    .rb_synced (rb_synced),
    .rdata     (reg_rdata),
    .cfg0_flat (cfg0_flat),
    .chip_sel  (chip_sel),
    .ecc_arm   (ecc_arm)
  );

  nand_strobe_seq seq_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (win_start),
    .start_wr   (bus_we),
    .start_kind (decode_kind(bus_addr[2], bus_addr[3])),
    .start_data (bus_wdata[7:0]),
    .t_setup    (cfg_setup(sel_cfg)),
    .t_width    (cfg_width(sel_cfg)),
    .t_hold     (cfg_hold(sel_cfg)),
    .dq_in      (nand_dq_in),
    .idle       (seq_idle),
    .active     (seq_active),
    .done       (seq_done),
    .cle        (nand_cle),
    .ale        (nand_ale),
    .we_n       (nand_we_n),
    .re_n       (nand_re_n),
    .dq_out     (nand_dq_out),
    .dq_oe      (nand_dq_oe),
    .rd_byte    (rd_byte)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= '0;
    else if (win_start) sel_q <= chip_sel;
  end

  generate
    for (genvar c = 0; c < NUM_CS; c++) begin : g_ce
      assign nand_ce_n[c] = !((seq_active && sel_q == SEL_W'(c)) ||
                              cfg_force(cfg0_flat[c*REG_W +: REG_W]));
    end
  endgenerate

  assign bus_wait  = bus_req && bus_win && !seq_done;
  assign bus_rdata = bus_win ? {{(REG_W-8){1'b0}}, rd_byte} : reg_rdata;
endmodule

// File: rtl/nand_bus_bridge_chk.sv
module nand_bus_bridge_chk #(
  parameter int NUM_CS = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_req,
  input logic              bus_we,
  input logic              bus_win,
  input logic [7:0]        bus_addr,
  input logic              bus_wait,
  input logic [NUM_CS-1:0] nand_ce_n,
  input logic              nand_cle,
  input logic              nand_ale,
  input logic              nand_we_n,
  input logic              nand_re_n,
  input logic              nand_dq_oe,
  input logic              ecc_arm
);
  p_strobe_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(!nand_we_n && !nand_re_n));

  p_latch_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(nand_cle && nand_ale));

  p_ce_on_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!nand_we_n || !nand_re_n) |-> (nand_ce_n != {NUM_CS{1'b1}}));

  p_write_drives_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !nand_we_n |-> nand_dq_oe);

  p_read_floats_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !nand_re_n |-> !nand_dq_oe);

  p_reg_nowait_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_win) |-> !bus_wait);

  p_done_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_win && !bus_wait) |-> (nand_we_n && nand_re_n));

  p_arm_after_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ecc_arm |-> $past(bus_req && bus_we && !bus_win && bus_addr[7:2] == 6'd18));
endmodule

bind nand_bus_bridge nand_bus_bridge_chk #(.NUM_CS(NUM_CS)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_req    (bus_req),
  .bus_we     (bus_we),
  .bus_win    (bus_win),
  .bus_addr   (bus_addr),
  .bus_wait   (bus_wait),
  .nand_ce_n  (nand_ce_n),
  .nand_cle   (nand_cle),
  .nand_ale   (nand_ale),
  .nand_we_n  (nand_we_n),
  .nand_re_n  (nand_re_n),
  .nand_dq_oe (nand_dq_oe),
  .ecc_arm    (ecc_arm)
);

// File: tb/nand_bus_bridge_tb.sv
`timescale 1ns/1ps
module nand_bus_bridge_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_req = 1'b0, bus_we = 1'b0, bus_win = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_wait;
  logic [3:0]  nand_ce_n;
  logic        nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe, ecc_arm;
  logic [7:0]  nand_dq_out;
  logic [7:0]  nand_dq_in = '0;
  logic        nand_rb = 1'b0;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  nand_bus_bridge dut_i (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we), .bus_win(bus_win),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_wait(bus_wait),
    .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_we_n(nand_we_n),
    .nand_re_n(nand_re_n), .nand_dq_out(nand_dq_out), .nand_dq_oe(nand_dq_oe),
    .nand_dq_in(nand_dq_in), .nand_rb(nand_rb), .ecc_arm(ecc_arm)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_req = 1; bus_we = 1; bus_win = 0; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_req = 0; bus_we = 0;
  endtask

  task automatic reg_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_req = 1; bus_we = 0; bus_win = 0; bus_addr = a;
    #1 d = bus_rdata;
    check(!bus_wait, "R8 no wait on register read", {31'b0, bus_wait}, 0);
    bus_req = 0;
  endtask

  // one window access; records what the flash pins showed while the bus stalled
  task automatic win_acc(input logic we, input logic [7:0] a, input logic [7:0] wd,
                         output int waits, output int we_lo, output int re_lo,
                         output logic cle_s, output logic ale_s, output logic [3:0] ce_s,
                         output logic [7:0] dq_s, output logic oe_s, output logic [31:0] rd);
    waits = 0; we_lo = 0; re_lo = 0; cle_s = 0; ale_s = 0; ce_s = '1; dq_s = '0; oe_s = 0;
    @(negedge clk);
    bus_req = 1; bus_we = we; bus_win = 1; bus_addr = a; bus_wdata = {24'h0, wd};
    for (int i = 0; i < 300; i++) begin
      #1;
      if (!bus_wait) break;
      waits++;
      if (!nand_we_n || !nand_re_n) begin
        if (!nand_we_n) we_lo++;
        if (!nand_re_n) re_lo++;
        cle_s = nand_cle; ale_s = nand_ale; ce_s = nand_ce_n;
        dq_s = nand_dq_out; oe_s = nand_dq_oe;
      end
      @(negedge clk);
    end
    rd = bus_rdata;
    bus_req = 0; bus_win = 0; bus_we = 0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    #1;
    check(nand_ce_n == 4'hF, "R1 ce_n after reset", {28'b0, nand_ce_n}, 32'hF);
    check(nand_we_n && nand_re_n, "R1 strobes idle", {30'b0, nand_we_n, nand_re_n}, 3);
    check(!nand_cle && !nand_ale, "R1 latches low", {30'b0, nand_cle, nand_ale}, 0);
    check(!bus_wait, "R1 no wait idle", {31'b0, bus_wait}, 0);
    reg_read(8'h00, d); check(d == 0, "R1 cfg reset", d, 0);
    reg_read(8'h38, d); check(d == 0, "R1 mode reset", d, 0);
    reg_read(8'h44, d); check(d == 0, "R1 ecc count reset", d, 0);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    for (int c = 0; c < 4; c++)
      for (int w = 0; w < 3; w++)
        reg_write(8'(4 * (3 * c + w)), 32'h1000_0000 + 32'(c * 16 + w) * 32'h0101_0000 + 32'h0A0);
    for (int c = 0; c < 4; c++)
      for (int w = 0; w < 3; w++) begin
        reg_read(8'(4 * (3 * c + w)), d);
        check(d == 32'h1000_0000 + 32'(c * 16 + w) * 32'h0101_0000 + 32'h0A0, "R8 cfg readback",
              d, 32'h1000_0000 + 32'(c * 16 + w) * 32'h0101_0000 + 32'h0A0);
      end
    reg_write(8'h40, 32'hC0DE_0001); reg_write(8'h44, 32'h0000_0200);
    reg_write(8'h38, 32'h0000_0002);
    reg_read(8'h40, d); check(d == 32'hC0DE_0001, "R8 ecc code", d, 32'hC0DE_0001);
    reg_read(8'h44, d); check(d == 32'h200, "R8 ecc count", d, 32'h200);
    reg_read(8'h38, d); check(d == 2, "R8 mode", d, 2);
    for (int k = 0; k < 12; k++) reg_write(8'(4 * k), 32'h0);
    reg_write(8'h38, 0);
  endtask

  task automatic t_status();
    logic [31:0] d;
    @(negedge clk); nand_rb = 1;
    @(negedge clk);
    reg_read(8'h30, d); check(d == 1, "R9 ready after two edges", d, 1);
    reg_write(8'h30, 32'hFFFF_FFFF);
    reg_read(8'h30, d); check(d == 1, "R9 status write ignored", d, 1);
    @(negedge clk); nand_rb = 0;
    @(posedge clk); #1;
    bus_req = 1; bus_win = 0; bus_addr = 8'h30; #0.5;
    check(bus_rdata == 1, "R9 one edge still old", bus_rdata, 1);
    bus_req = 0;
    @(negedge clk); @(negedge clk);
    reg_read(8'h30, d); check(d == 0, "R9 busy shown", d, 0);
  endtask

  task automatic t_kinds();
    int wt, wl, rl; logic cl, al, oe; logic [3:0] ce; logic [7:0] dq; logic [31:0] rd;
    win_acc(1, 8'h04, 8'h70, wt, wl, rl, cl, al, ce, dq, oe, rd);
    check(cl && !al, "R2 command cycle", {30'b0, cl, al}, 2);
    check(wl == 1 && rl == 0, "R3 one write pulse", 32'(wl), 1);
    check(dq == 8'h70 && oe, "R3 data on bus", {23'b0, oe, dq}, 32'h170);
    check(wt == 4, "R5 default stall length", 32'(wt), 4);
    win_acc(1, 8'h08, 8'h3C, wt, wl, rl, cl, al, ce, dq, oe, rd);
    check(!cl && al, "R2 address cycle", {30'b0, cl, al}, 1);
    check(dq == 8'h3C, "R3 address byte", {24'b0, dq}, 32'h3C);
    win_acc(1, 8'h00, 8'hE1, wt, wl, rl, cl, al, ce, dq, oe, rd);
    check(!cl && !al, "R2 data cycle", {30'b0, cl, al}, 0);
    win_acc(1, 8'h0C, 8'h11, wt, wl, rl, cl, al, ce, dq, oe, rd);
    check(cl && !al, "R2 both bits command wins", {30'b0, cl, al}, 2);
    check(ce == 4'b1110, "R6 chip 0 by default", {28'b0, ce}, 32'hE);
  endtask

  task automatic t_read();
    int wt, wl, rl; logic cl, al, oe; logic [3:0] ce; logic [7:0] dq; logic [31:0] rd;
    nand_dq_in = 8'hA5;
    win_acc(0, 8'h00, 8'h00, wt, wl, rl, cl, al, ce, dq, oe, rd);
    check(rl == 1 && wl == 0, "R4 one read pulse", 32'(rl), 1);
    check(!oe, "R4 bus released", {31'b0, oe}, 0);
    check(rd == 32'hA5, "R4 read byte", rd, 32'hA5);
    nand_dq_in = 8'h00;
  endtask

  task automatic t_timing();
    int wt, wl, rl; logic cl, al, oe; logic [3:0] ce; logic [7:0] dq; logic [31:0] rd;
    reg_write(8'h0C, 32'h0000_1032);  // chip 1: setup 2, width 3, hold 1
    reg_write(8'h38, 32'h1);
    win_acc(1, 8'h00, 8'h5A, wt, wl, rl, cl, al, ce, dq, oe, rd);
    check(wl == 4, "R5 strobe width", 32'(wl), 4);
    check(wt == 10, "R5 stall length", 32'(wt), 10);
    check(ce == 4'b1101, "R6 chip 1 selected", {28'b0, ce}, 32'hD);
    reg_write(8'h24, 32'h0000_2050);  // chip 3: setup 0, width 5, hold 2
    reg_write(8'h38, 32'h3);
    nand_dq_in = 8'h3E;
    win_acc(0, 8'h00, 8'h00, wt, wl, rl, cl, al, ce, dq, oe, rd);
    check(rl == 6 && wt == 11, "R5 read timing chip 3", 32'(wt), 11);
    check(ce == 4'b0111, "R6 chip 3 selected", {28'b0, ce}, 32'h7);
    check(rd == 32'h3E, "R4 read byte long strobe", rd, 32'h3E);
    nand_dq_in = 8'h00;
  endtask

  task automatic t_force();
    int wt, wl, rl; logic cl, al, oe; logic [3:0] ce; logic [7:0] dq; logic [31:0] rd;
    reg_write(8'h00, 32'h0000_0200);
    @(negedge clk); #1;
    check(nand_ce_n == 4'b1110, "R7 forced low idle", {28'b0, nand_ce_n}, 32'hE);
    reg_write(8'h38, 32'h2);
    win_acc(1, 8'h04, 8'hFF, wt, wl, rl, cl, al, ce, dq, oe, rd);
    check(ce == 4'b1010, "R7 forced plus selected", {28'b0, ce}, 32'hA);
    @(negedge clk); #1;
    check(nand_ce_n == 4'b1110, "R7 still forced after access", {28'b0, nand_ce_n}, 32'hE);
    reg_write(8'h00, 32'h0);
    @(negedge clk); #1;
    check(nand_ce_n == 4'hF, "R7 released", {28'b0, nand_ce_n}, 32'hF);
  endtask

  task automatic t_arm();
    logic a1, a2;
    reg_write(8'h44, 32'h1);
    #1 check(!ecc_arm, "R10 no arm on count write", {31'b0, ecc_arm}, 0);
    @(negedge clk);
    bus_req = 1; bus_we = 1; bus_win = 0; bus_addr = 8'h48; bus_wdata = 32'h8010_0000;
    @(negedge clk); bus_req = 0; bus_we = 0; #1 a1 = ecc_arm;
    @(negedge clk); #1 a2 = ecc_arm;
    check(a1 && !a2, "R10 single arm pulse", {30'b0, a1, a2}, 2);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_regs();
    t_status();
    t_kinds();
    t_read();
    t_timing();
    t_force();
    t_arm();
    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule